// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Set/Clear Latches

This block is a general-purpose pin controller attached to a simple 32-bit memory-mapped bus made up of a word address, a write strobe, write data and combinational read data. Each pin owns a 3-bit function field. Ten of these fields are packed into each select word. Code 000 makes the pin an input and code 001 makes it an output. Any other code is stored and reads back, but the pin still behaves as an input.

Software never needs a read-modify-write to move an output. A word written to a set address raises the output latch of every pin whose bit is 1. A word written to a clear address lowers the latch of every pin whose bit is 1. Zero bits leave the latches alone. The latches keep changing even while a pin is an input, so a pin that is later turned into an output shows the last value that software requested. A level word reads back each external pin after a two-flop synchronizer.

Top module: `gpio_setclr`

## Requirements
- R1: While reset is low, and right after it is released, every function field is 000, every output latch is 0, every output enable is 0, and every select word reads 0.
- R2: The field of pin n lies at bits 3*(n mod 10)+2 down to 3*(n mod 10) of the select word at byte offset 4*(n/10), starting from offset 0x00. Bits 31:30 read as 0. Fields of pins that do not exist read as 0.
- R3: Output enable n is 1 exactly when the field of pin n holds 001. Codes 000 and 010 to 111 leave it at 0. The enables change only on a write to a select word.
- R4: Writing the word at 0x1C + 4*w drives the latch of pin 32*w+b high for every 1 in bit b, from the next clock edge onward. Zero bits change nothing.
- R5: Writing the word at 0x28 + 4*w drives the latch of pin 32*w+b low for every 1 in bit b, from the next clock edge onward. Zero bits change nothing.
- R6: Set and clear writes update the latch of a pin whose field is not 001, while its output enable stays 0. Switching that pin to 001 then presents the stored latch value.
- R7: The set and clear addresses (0x1C, 0x20, 0x28, 0x2C) always read as 0.
- R8: The word at 0x34 + 4*w returns pin input 32*w+b in bit b. A change on a pin input becomes readable after exactly two rising clock edges. Bits above the last pin read as 0.
- R9: Bits 22 to 31 of the upper set and clear words (offsets 0x20 and 0x2C) have no effect.
- R10: When one pin receives a clear write and then a set write in consecutive cycles, or a set and then a clear, the later write decides the latch value.
- R11: Unmapped word offsets (0x18, 0x24, 0x30, 0x3C and above) and addresses whose two low bits are not 00 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the accessed word |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NUM_PINS (54) | External pin levels, asynchronous |
| pin_out | output | NUM_PINS (54) | Output latch value of each pin |
| pin_oe | output | NUM_PINS (54) | Output enable of each pin |

## Verification
The bench builds the block with its default values: 54 pins and an 8-bit address. With this size the last select word holds only four real fields, and the upper set, clear and level words carry 22 live bits and 10 dead ones. That makes the partial-word corners reachable: dead select fields reading 0, dead set and clear bits being ignored, and zero-filled level bits. A 32-bit lower word also lets the checker compare whole words of latches and inputs against the set, clear and level traffic.

// File: rtl/gpio_setclr_pkg.sv
// Package gpio_setclr_pkg
// Shared constants and the address-region type for the pin controller.
// Assumes word-aligned byte addresses and a bank of at most 64 pins, so
// that the select, set, clear and level regions never overlap.
package gpio_setclr_pkg;

    localparam int FN_W        = 3;
    localparam int FN_PER_WORD = 10;
    localparam int BUS_W       = 32;

    localparam logic [FN_W-1:0] FN_INPUT  = 3'b000;
    localparam logic [FN_W-1:0] FN_OUTPUT = 3'b001;

    // word offsets (byte offset / 4) of the first word of each region
    localparam int SEL_WORD0 = 0;   // 0x00
    localparam int SET_WORD0 = 7;   // 0x1C
    localparam int CLR_WORD0 = 10;  // 0x28
    localparam int LEV_WORD0 = 13;  // 0x34

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SEL,
        RG_SET,
        RG_CLR,
        RG_LEV
    } region_e;

endpackage

// File: rtl/gpio_addr_decode.sv
// Module gpio_addr_decode
// Turns a byte address into a region and a word index inside that region.
// Assumes the region bases from the package and a bank of at most 64 pins.
// Misaligned addresses decode to no region.
module gpio_addr_decode
    import gpio_setclr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_SEL   = 6,
    parameter int NUM_WORDS = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [3:0]        idx
);

    int w;

    // Purpose: classify the word offset into one region and its index.
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        w      = int'(addr[ADDR_W-1:2]);
        if (addr[1:0] != 2'b00) begin
            region = RG_NONE;
        end else if (w >= SEL_WORD0 && w < SEL_WORD0 + NUM_SEL) begin
            region = RG_SEL;
            idx    = 4'(w - SEL_WORD0);
        end else if (w >= SET_WORD0 && w < SET_WORD0 + NUM_WORDS) begin
            region = RG_SET;
            idx    = 4'(w - SET_WORD0);
        end else if (w >= CLR_WORD0 && w < CLR_WORD0 + NUM_WORDS) begin
            region = RG_CLR;
            idx    = 4'(w - CLR_WORD0);
        end else if (w >= LEV_WORD0 && w < LEV_WORD0 + NUM_WORDS) begin
            region = RG_LEV;
            idx    = 4'(w - LEV_WORD0);
        end
    end

endmodule

// File: rtl/gpio_fsel_regs.sv
// Module gpio_fsel_regs
// Holds one 3-bit function field per pin, ten fields per select word.
// It writes the addressed word, reads it back and derives the output
// enables. Only code 001 enables a pin. Fields of missing pins are
// not stored and read as zero.
module gpio_fsel_regs
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [3:0]                  idx,
    input  logic [FN_W*FN_PER_WORD-1:0] wr_data,
    output logic [BUS_W-1:0]            rd_data,
    output logic [NUM_PINS-1:0]         oe
);

    logic [NUM_PINS-1:0][FN_W-1:0] fn_q;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int REG = p / FN_PER_WORD;
        localparam int LSB = FN_W * (p % FN_PER_WORD);

        // Purpose: store this pin's field when its select word is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fn_q[p] <= FN_INPUT;
            end else if (wr_en && idx == 4'(REG)) begin
                fn_q[p] <= wr_data[LSB +: FN_W];
            end
        end

        // Purpose: drive the pin only for the output code.
        assign oe[p] = (fn_q[p] == FN_OUTPUT);
    end

    // Purpose: gather the fields of the addressed select word.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (p / FN_PER_WORD == int'(idx)) begin
                rd_data[FN_W*(p%FN_PER_WORD) +: FN_W] = fn_q[p];
            end
        end
    end

endmodule

// File: rtl/gpio_out_latch.sv
// Module gpio_out_latch
// One output latch per pin, moved only by write-one-to-set and
// write-one-to-clear words. Assumes at most one bus write per cycle, so
// set and clear never arrive together. Latches update whatever the
// pin's function code is. Bits for missing pins are ignored.
module gpio_out_latch
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic                clr_en,
    input  logic [3:0]          idx,
    input  logic [BUS_W-1:0]    wdata,
    output logic [NUM_PINS-1:0] latch_q
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam int WORD = p / BUS_W;
        localparam int BIT  = p % BUS_W;

        logic hit;
        assign hit = (idx == 4'(WORD)) && wdata[BIT];

        // Purpose: raise or lower this latch on a selected one-bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch_q[p] <= 1'b0;
            end else if (set_en && hit) begin
                latch_q[p] <= 1'b1;
            end else if (clr_en && hit) begin
                latch_q[p] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Two-flop synchronizer for asynchronous pin levels. A change at the
// input is visible at the output after the second rising edge.
module gpio_in_sync #(
    parameter int WIDTH = 54
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    // Purpose: pass the inputs through two register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_setclr.sv
// Module gpio_setclr
// Top of the pin controller. It decodes the bus, routes writes to the
// select fields and the set/clear latches, and muxes read data.
// Assumes NUM_PINS <= 64 and one access per cycle. Reads are
// combinational on bus_addr.
module gpio_setclr
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam int NUM_SEL   = (NUM_PINS + FN_PER_WORD - 1) / FN_PER_WORD;
    localparam int NUM_WORDS = (NUM_PINS + BUS_W - 1) / BUS_W;

    region_e              region;
    logic [3:0]           idx;
    logic [BUS_W-1:0]     sel_rdata;
    logic [BUS_W-1:0]     lev_word;
    logic [NUM_PINS-1:0]  lev_sync;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_SEL   (NUM_SEL),
        .NUM_WORDS (NUM_WORDS)
    ) u_decode (
        .addr   (bus_addr),
        .region (region),
        .idx    (idx)
    );

    gpio_fsel_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_fsel (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && region == RG_SEL),
        .idx     (idx),
        .wr_data (bus_wdata[FN_W*FN_PER_WORD-1:0]),
        .rd_data (sel_rdata),
        .oe      (pin_oe)
    );

    gpio_out_latch #(
        .NUM_PINS (NUM_PINS)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (bus_we && region == RG_SET),
        .clr_en  (bus_we && region == RG_CLR),
        .idx     (idx),
        .wdata   (bus_wdata),
        .latch_q (pin_out)
    );

    gpio_in_sync #(
        .WIDTH (NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lev_sync)
    );

    // Purpose: pack the synchronized levels of the addressed word.
    always_comb begin
        lev_word = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (p / BUS_W == int'(idx)) begin
                lev_word[p % BUS_W] = lev_sync[p];
            end
        end
    end

    // Purpose: select read data by region; set/clear/unmapped read zero.
    always_comb begin
        unique case (region)
            RG_SEL:  bus_rdata = sel_rdata;
            RG_LEV:  bus_rdata = lev_word;
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_setclr_checker.sv
// Module gpio_setclr_checker
// Port-level properties of the pin controller. It is bound to every
// instance of gpio_setclr and assumes the default offsets and more than
// 32 pins.
module gpio_setclr_checker
    import gpio_setclr_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic [BUS_W-1:0]    bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    localparam int NUM_SEL = (NUM_PINS + FN_PER_WORD - 1) / FN_PER_WORD;
    localparam int HI_W    = NUM_PINS - BUS_W;

    logic [1:0] age_q;
    logic       sel_wr;
    logic       zero_rd;

    // Purpose: count the cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign sel_wr  = bus_we && bus_addr[1:0] == 2'b00
                     && int'(bus_addr[ADDR_W-1:2]) < NUM_SEL;
    assign zero_rd = bus_addr == 8'h1C || bus_addr == 8'h20
                     || bus_addr == 8'h28 || bus_addr == 8'h2C
                     || bus_addr == 8'h18 || bus_addr == 8'h30
                     || bus_addr >= 8'h3C;

    assert_set_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h1C) |=>
            pin_out[BUS_W-1:0] == ($past(pin_out[BUS_W-1:0]) | $past(bus_wdata)));

    assert_clr_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h28) |=>
            pin_out[BUS_W-1:0] == ($past(pin_out[BUS_W-1:0]) & ~$past(bus_wdata)));

    assert_set_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 8'h20) |=>
            pin_out[NUM_PINS-1:BUS_W] ==
            ($past(pin_out[NUM_PINS-1:BUS_W]) | $past(bus_wdata[HI_W-1:0])));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(pin_out) && $stable(pin_oe));

    assert_oe_only_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_wr |=> $stable(pin_oe));

    assert_zero_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_rd |-> bus_rdata == '0);

    assert_level_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2 && bus_addr == 8'h34) |->
            bus_rdata == $past(pin_in[BUS_W-1:0], 2));

endmodule

bind gpio_setclr gpio_setclr_checker #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/gpio_setclr_bench.sv
module gpio_setclr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 54;
    localparam int NVEC       = 11;

    typedef struct packed {
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [7:0]  chk;
        logic [31:0] exp_rd;
        logic [63:0] exp_out;
        logic [63:0] exp_oe;
        logic [7:0]  req;
    } vec_t;

    // each row: write addr/wdata, then read chk and compare pins
    localparam vec_t VECS [NVEC] = '{
        // R2 R3: pin 4 -> output
        '{8'h00, 32'h0000_1000, 8'h00, 32'h0000_1000, 64'h0, 64'h10, 8'd3},
        // R4 R6 R7: set pins 4 and 9 (9 still input)
        '{8'h1C, 32'h0000_0210, 8'h1C, 32'h0, 64'h210, 64'h10, 8'd4},
        // R6: pin 9 -> output shows stored high
        '{8'h00, 32'h0800_1000, 8'h00, 32'h0800_1000, 64'h210, 64'h210, 8'd6},
        // R5 R7: clear pin 4
        '{8'h28, 32'h0000_0010, 8'h28, 32'h0, 64'h200, 64'h210, 8'd5},
        // R3: code 010 on pin 32 gives no enable
        '{8'h0C, 32'h0000_0080, 8'h0C, 32'h0000_0080, 64'h200, 64'h210, 8'd3},
        // R9: all ones to upper set word, dead bits ignored
        '{8'h20, 32'hFFFF_FFFF, 8'h20, 32'h0, 64'h3F_FFFF_0000_0200, 64'h210, 8'd9},
        // R2: pin 53 -> output in last select word
        '{8'h14, 32'h0000_0200, 8'h14, 32'h0000_0200, 64'h3F_FFFF_0000_0200, 64'h20_0000_0000_0210, 8'd2},
        // R5: clear pin 53 via upper clear word
        '{8'h2C, 32'h0020_0000, 8'h2C, 32'h0, 64'h1F_FFFF_0000_0200, 64'h20_0000_0000_0210, 8'd5},
        // R2 R3: dead fields read zero, code 111 drops enable
        '{8'h14, 32'hFFFF_FFFF, 8'h14, 32'h0000_0FFF, 64'h1F_FFFF_0000_0200, 64'h210, 8'd2},
        // R11: unmapped write changes nothing, reads zero
        '{8'h18, 32'hFFFF_FFFF, 8'h18, 32'h0, 64'h1F_FFFF_0000_0200, 64'h210, 8'd11},
        // R2 R3: bits 31:30 dead, code 111 everywhere in word 0
        '{8'h00, 32'hFFFF_FFFF, 8'h00, 32'h3FFF_FFFF, 64'h1F_FFFF_0000_0200, 64'h0, 8'd3}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_setclr #(.NUM_PINS(NP), .ADDR_W(8)) u_gpio_setclr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input int req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int k = 0; k < 6; k++) begin
            read_at(8'(4 * k), rd);
            check(1, "select word after reset", 64'(rd), 64'h0);
        end
        check(1, "latches after reset", 64'(pin_out), 64'h0);
        check(1, "enables after reset", 64'(pin_oe), 64'h0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            bus_write(VECS[v].addr, VECS[v].wdata);
            read_at(VECS[v].chk, rd);
            check(int'(VECS[v].req), "read data", 64'(rd), 64'(VECS[v].exp_rd));
            check(int'(VECS[v].req), "pin_out", 64'(pin_out), VECS[v].exp_out[NP-1:0]);
            check(int'(VECS[v].req), "pin_oe", 64'(pin_oe), VECS[v].exp_oe[NP-1:0]);
        end

        // R11: other unmapped and misaligned addresses
        read_at(8'h30, rd);
        check(11, "read 0x30", 64'(rd), 64'h0);
        read_at(8'h01, rd);
        check(11, "misaligned read", 64'(rd), 64'h0);
        bus_write(8'h3C, 32'hFFFF_FFFF);
        check(11, "write 0x3C latches", 64'(pin_out), 64'h1F_FFFF_0000_0200);

        // R10: clear then set on pin 32 back to back, then set then clear
        bus_write(8'h2C, 32'h1);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
        @(negedge clk);
        bus_we = 1'b0;
        check(10, "clear then set pin32", 64'(pin_out[32]), 64'h1);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1;
        @(negedge clk);
        bus_addr = 8'h2C;
        @(negedge clk);
        bus_we = 1'b0;
        check(10, "set then clear pin32", 64'(pin_out[32]), 64'h0);

        // R8: two-edge input latency and zero-filled upper level bits
        @(negedge clk);
        pin_in   = 54'h2B_CAFE_1234_5678;
        bus_addr = 8'h34;
        @(negedge clk);
        #1;
        check(8, "level after one edge", 64'(bus_rdata), 64'h0);
        @(negedge clk);
        #1;
        check(8, "level word 0 after two edges", 64'(bus_rdata), 64'h1234_5678);
        read_at(8'h38, rd);
        check(8, "level word 1", 64'(rd), 64'h002B_CAFE);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(1, "latches in reset", 64'(pin_out), 64'h0);
        check(1, "enables in reset", 64'(pin_oe), 64'h0);
        rst_n = 1'b1;
        read_at(8'h14, rd);
        check(1, "select word 5 after reset", 64'(rd), 64'h0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule